// File: doc/BRIEF.md
# Idle-Aware Hinted Clock Gate Controller

This block produces clock-enable levels for a set of peripheral units and a set of accelerator units. A separate clock-gate cell uses these levels. The block is controlled over a simple synchronous register bus: address, write strobe, write data and read data.

The peripheral enables are plain software switches. The accelerator enables work differently. Software only writes a hint saying that a unit's clock may stop. Hardware stops the clock only while the unit also reports that it is idle. Each idle indication is asynchronous and passes through a synchronizer before it is used. The enable that is driven at any moment can be read back from a read-only status word. Software can therefore see whether its request has taken effect.

Read data is registered: the word for the address presented in one cycle appears on the read-data port in the following cycle.

Top module: `hinted_clk_gate_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after reset, `peri_en` is 2'b11 and `accel_en` is 3'b111. After reset the enable word, the hint word and the status word read 0x3, 0x7 and 0x7, and `bus_rdata` is 0 while reset is held.
- R2: A write to byte offset 0x00 loads `peri_en[1:0]` from `bus_wdata[1:0]` at that clock edge. 1 means enabled and 0 means disabled.
- R3: A write to byte offset 0x04 loads the three hint bits from `bus_wdata[2:0]`. Bit i belongs to accelerator i. Reading offset 0x04 returns them in the same positions.
- R4: `accel_en[i]` goes low only when hint bit i is 0 and idle bit i is high as seen after the two synchronizer stages. It never goes low while the synchronized idle bit is low. An idle bit first applied before edge k with hint 0 drops the enable after edge k+2.
- R5: A hint bit of 1 keeps its enable high. When a hint bit is written to 1 at edge k, the enable is high after edge k+1. When idle falls before edge k, the enable is high again after edge k+2.
- R6: Reading byte offset 0x08 returns `accel_en` in bits [2:0], in the same positions as the hint bits. The value is the enable driven in the cycle in which the address was presented.
- R7: A write to offset 0x08 or to any unmapped offset changes no enable and no register. Unused bits ignore writes and read as 0. Unmapped offsets read 0.
- R8: `bus_rdata` is registered. It shows the word for the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| idle_async | input | 3 | Asynchronous per-accelerator idle indications |
| peri_en | output | 2 | Software-owned peripheral clock enables |
| accel_en | output | 3 | Hinted accelerator clock enables |

## Verification
A wrong hint or enable register shows on `peri_en` or `accel_en` in the cycle after the faulty write. A synchronizer that is too short or too long shifts every falling and rising edge of `accel_en` by a cycle relative to the idle input. A status or read-mux fault shows on `bus_rdata` one cycle after the address is presented. The bench therefore compares all three outputs against its model on every clock, while idle patterns toggle both with hints cleared and with hints set.

// File: rtl/cg_pkg.sv
package cg_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 32;
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
  parameter logic [ADDR_W-1:0] OFS_HINT   = 8'h04;
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h08;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/cg_hint_gate.sv
module cg_hint_gate (
  input  logic clk,
  input  logic rst,
  input  logic hint,
  input  logic idle_s,
  output logic en
);
  logic en_q;

  // Clock stops only with permission (hint low) and a quiet unit.
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else     en_q <= hint | ~idle_s;
  end

  assign en = en_q;

  assert_off_needs_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(idle_s && !hint));
endmodule

// File: rtl/cg_regbank.sv
module cg_regbank
  import cg_pkg::*;
#(
  parameter int N_PERI  = 2,
  parameter int N_ACCEL = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_ACCEL-1:0] status,
  output logic [N_PERI-1:0]  peri_q,
  output logic [N_ACCEL-1:0] hint_q,
  output logic [DATA_W-1:0]  rdata
);
  localparam int PAD_P = DATA_W - N_PERI;
  localparam int PAD_A = DATA_W - N_ACCEL;

  logic [DATA_W-1:0] rd_next;
  logic              hit_en, hit_hint, hit_stat;
  logic              unused_wdata;

  assign hit_en   = (addr == OFS_ENABLE);
  assign hit_hint = (addr == OFS_HINT);
  assign hit_stat = (addr == OFS_STATUS);
  assign unused_wdata = ^wdata[DATA_W-1:N_ACCEL];

  always_ff @(posedge clk) begin
    if (rst) begin
      peri_q <= '1;
      hint_q <= '1;
    end else if (we) begin
      if (hit_en)   peri_q <= wdata[N_PERI-1:0];
      if (hit_hint) hint_q <= wdata[N_ACCEL-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_en)   rd_next = {{PAD_P{1'b0}}, peri_q};
    if (hit_hint) rd_next = {{PAD_A{1'b0}}, hint_q};
    if (hit_stat) rd_next = {{PAD_A{1'b0}}, status};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assert_peri_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == OFS_ENABLE) |=> peri_q == $past(wdata[N_PERI-1:0]));
  assert_status_read_R6: assert property (@(posedge clk) disable iff (rst)
    (addr == OFS_STATUS) |=> rdata == {{PAD_A{1'b0}}, $past(status)});
  assert_status_ro_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == OFS_STATUS) |=> ($stable(hint_q) && $stable(peri_q)));
endmodule

// File: rtl/hinted_clk_gate_ctrl.sv
module hinted_clk_gate_ctrl
  import cg_pkg::*;
#(
  parameter int N_PERI      = 2,
  parameter int N_ACCEL     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [N_ACCEL-1:0] idle_async,
  output logic [N_PERI-1:0]  peri_en,
  output logic [N_ACCEL-1:0] accel_en
);
  logic [N_ACCEL-1:0] hint_q;
  logic [N_ACCEL-1:0] idle_s;

  cg_regbank #(.N_PERI(N_PERI), .N_ACCEL(N_ACCEL)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .status(accel_en), .peri_q(peri_en), .hint_q(hint_q), .rdata(bus_rdata)
  );

  cg_sync #(.WIDTH(N_ACCEL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(idle_async), .d_out(idle_s)
  );

  for (genvar i = 0; i < N_ACCEL; i++) begin : g_unit
    cg_hint_gate u_gate (
      .clk(clk), .rst(rst), .hint(hint_q[i]), .idle_s(idle_s[i]), .en(accel_en[i])
    );

    assert_busy_keeps_on_R4: assert property (@(posedge clk) disable iff (rst)
      !idle_s[i] |=> accel_en[i]);
    assert_hint_keeps_on_R5: assert property (@(posedge clk) disable iff (rst)
      hint_q[i] |=> accel_en[i]);
  end
endmodule

// File: tb/hinted_clk_gate_ctrl_test.sv
`timescale 1ns/1ps
module hinted_clk_gate_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [2:0]  idle = 0;
  logic [31:0] rdata;
  logic [1:0]  peri_en;
  logic [2:0]  accel_en;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hinted_clk_gate_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .idle_async(idle), .peri_en(peri_en), .accel_en(accel_en)
  );

  // Behavioural reference model
  int m_peri[2];
  int m_hint[3];
  int m_en[3];
  int idle_q[$];
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_peri[i]) m_peri[i] = 1;
      foreach (m_hint[i]) begin m_hint[i] = 1; m_en[i] = 1; end
      idle_q = {0, 0};
      m_rd = 0;
    end else begin
      int seen;
      logic [31:0] nrd;
      seen = idle_q[0];
      nrd = 0;
      case (addr)
        8'h00: nrd = m_peri[0] + 2 * m_peri[1];
        8'h04: nrd = m_hint[0] + 2 * m_hint[1] + 4 * m_hint[2];
        8'h08: nrd = m_en[0] + 2 * m_en[1] + 4 * m_en[2];
        default: nrd = 0;
      endcase
      m_rd = nrd;
      for (int i = 0; i < 3; i++)
        m_en[i] = (m_hint[i] == 0 && ((seen >> i) & 1) == 1) ? 0 : 1;
      void'(idle_q.pop_front());
      idle_q.push_back(int'(idle));
      if (we && addr == 8'h00) for (int i = 0; i < 2; i++) m_peri[i] = wdata[i];
      if (we && addr == 8'h04) for (int i = 0; i < 3; i++) m_hint[i] = wdata[i];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R2 peri_en", 32'(peri_en), 32'(m_peri[0] + 2 * m_peri[1]));
    check("R4 R5 accel_en", 32'(accel_en), 32'(m_en[0] + 2 * m_en[1] + 4 * m_en[2]));
    check("R6 R7 R8 bus_rdata", rdata, m_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1 addr = a; we = 1; wdata = d;
    @(negedge clk); #1 we = 0; addr = 8'h0C;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); #1 addr = a;
    @(negedge clk); check(tag, rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    check("R1 reset peri_en", 32'(peri_en), 32'h3);
    check("R1 reset accel_en", 32'(accel_en), 32'h7);
    check("R1 reset rdata", rdata, 0);
    #1 rst = 0;
    rd_chk("R1 enable word", 8'h00, 32'h3);
    rd_chk("R1 hint word", 8'h04, 32'h7);
    rd_chk("R1 status word", 8'h08, 32'h7);
    // R2: peripheral enables
    wr(8'h00, 32'h1);
    check("R2 peri 01", 32'(peri_en), 32'h1);
    wr(8'h00, 32'hFFFF_FFFE);
    check("R2 peri 10", 32'(peri_en), 32'h2);
    rd_chk("R7 unused bits read 0", 8'h00, 32'h2);
    // R5: hint 1 keeps clock on while idle
    #1 idle = 3'b111;
    cyc(6);
    check("R5 hint forces on", 32'(accel_en), 32'h7);
    #1 idle = 3'b000;
    cyc(4);
    // R3/R4: hint 0 while busy keeps clocks on
    wr(8'h04, 32'hFFFF_FFF8);
    rd_chk("R3 hint readback", 8'h04, 32'h0);
    cyc(5);
    check("R4 busy stays on", 32'(accel_en), 32'h7);
    // R4: busy to idle on unit 0 stops it after sync
    @(negedge clk); #1 idle = 3'b001;
    cyc(2);
    check("R4 still on during sync", 32'(accel_en), 32'h7);
    cyc(1);
    check("R4 idle turns off", 32'(accel_en), 32'h6);
    rd_chk("R6 status shows off", 8'h08, 32'h6);
    // R5: idle drops, re-enable
    @(negedge clk); #1 idle = 3'b000;
    cyc(3);
    check("R5 busy re-enables", 32'(accel_en), 32'h7);
    // R5: hint back to 1 re-enables next cycle
    #1 idle = 3'b110;
    cyc(4);
    check("R4 units 1,2 off", 32'(accel_en), 32'h1);
    wr(8'h04, 32'h2);
    cyc(1);
    check("R5 hint reasserted", 32'(accel_en), 32'h3);
    // R7: write to status and unmapped offset
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R7 status write ignored", 32'(accel_en), 32'h3);
    rd_chk("R7 hint unchanged", 8'h04, 32'h2);
    rd_chk("R7 unmapped reads 0", 8'h0C, 32'h0);
    rd_chk("R7 unmapped 0x10", 8'h10, 32'h0);
    // Pseudo-random sweep, model compared every clock
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk); #1;
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
      idle = 3'(lfsr >> 3);
      addr = 8'(4 * ((lfsr >> 7) & 3));
      we = ((lfsr & 16'h0070) == 0);
      wdata = 32'(lfsr >> 9);
    end
    @(negedge clk); #1 we = 0;
    cyc(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule